// File: doc/BRIEF.md
# I2C Host SCL Clock Generator

This block produces the serial clock for the host side of an I2C interface. A programmable prescaler turns the system clock into a slower tick. A slot sequencer then counts those ticks through a fixed per-mode schedule. The schedule has a release phase, a phase that samples the line for a high level, a drive-low phase and a phase that checks the line went low. The line is open-drain: the block only turns a pull-down on or off, and it senses the wired line through a synchronizer.

A client device may stretch the clock by holding the line low. When the sequencer sees this, it stops in its current slot and raises a stretch status. It waits for the line to rise, and then needs a mode-dependent number of further high samples before it pulls the line low. A one-cycle strobe marks the start of every period. A sticky error flags any check slot that finds the line still high. START/STOP framing, data shifting, arbitration and clock-source selection are handled elsewhere.

Top module: `scl_clkgen`

## Requirements
- R1: The prescaler emits one tick every `baud`+1 clock cycles. In speed mode 0 (`mode` = 2'b00) one SCL period lasts 5 ticks, so consecutive `period_done` strobes are 5·(`baud`+1) cycles apart.
- R2: In speed mode 1 (`mode` = 2'b01) one SCL period lasts 4 ticks, i.e. 4·(`baud`+1) cycles between strobes.
- R3: In speed mode 2 (`mode` = 2'b10) one SCL period lasts 16 ticks. The reserved value 2'b11 behaves exactly like mode 2.
- R4: `scl_pull_low` is the only line drive and never drives high. It is asserted from the drive-low slot to the end of the period: 2 ticks in modes 0 and 1, and 10 ticks in mode 2. It is released only at a period start or on disable.
- R5: The first high sample is taken at the end of slot 2 (modes 0 and 1) or slot 6 (mode 2). If the synchronized line reads low there, the period is held and `stretch_active` is 1. Once the line is seen high, 2 (mode 0), 1 (mode 1) or 6 (mode 2) further high ticks are needed before the drive-low slot begins. If the line is released just after tick m, with m at least the sample slot, the period lasts (m + extra + slots from drive-low to end + 1)·(`baud`+1) cycles.
- R6: `low_err` is set when a check slot (every slot after the drive-low slot) reads the line high. It stays set until reset or until `en` is low.
- R7: `baud` and `mode` are captured only at the start of a period. A change made mid-period first affects the following period.
- R8: While `en` is low, the line is released and the slot and prescaler counters stay at zero. No strobe is issued. After `en` rises, the first period starts on the next clock, so the first strobe comes 1 + ticks·(`baud`+1) cycles after the edge that samples `en` high.
- R9: `period_done` is a one-cycle pulse in the cycle after the final tick of a period. The line is released in that same cycle.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the generator idle and clears the error |
| baud | input | BAUD_W | Prescaler value; the tick period is baud+1 cycles |
| mode | input | 2 | Speed mode: 0 = 5 ticks, 1 = 4 ticks, 2/3 = 16 ticks per period |
| scl_in | input | 1 | Sensed level of the wired SCL line |
| scl_pull_low | output | 1 | Enables the open-drain pull-down on SCL |
| period_done | output | 1 | One-cycle strobe at each period start after a completed period |
| stretch_active | output | 1 | High while waiting for a held-low line to rise |
| low_err | output | 1 | Sticky flag: a check slot found the line high |

## Verification
The assertions assume the wired line follows the pull-down within the synchronizer latency. They also assume `baud` is at least 2, so every tick lasts longer than the two synchronizer stages; otherwise a check slot could see a stale high level. The stimulus keeps `baud` between 2 and 7 and changes all inputs on falling clock edges. The modelled client releases the line right after a tick, so the cycle in which the release is noticed is known. A separate force-high input is raised only when the error path is being exercised.

// File: rtl/scl_gen_pkg.sv
// Package: shared widths, speed-mode codes and the per-mode slot schedule
// for the SCL generator. Slots are numbered from 1; slot 0 means idle.
package scl_gen_pkg;

    localparam int SLOT_W = 5;   // holds slot numbers up to 16
    localparam int CONF_W = 3;   // holds re-confirm counts up to 6

    typedef enum logic [1:0] {
        SPD_STD  = 2'd0,
        SPD_FAST = 2'd1,
        SPD_PLUS = 2'd2,
        SPD_RSVD = 2'd3
    } speed_t;

    typedef struct packed {
        logic [SLOT_W-1:0] last_slot;    // final slot of the period
        logic [SLOT_W-1:0] sample_slot;  // first slot that samples for high
        logic [SLOT_W-1:0] drive_slot;   // slot in which the line is pulled low
        logic [CONF_W-1:0] reconfirm;    // high ticks required after a stretch
    } sched_t;

    // Map a speed code to its schedule; the reserved code reuses mode 2.
    function automatic sched_t sched_for(input logic [1:0] code);
        sched_t s;
        case (speed_t'(code))
            SPD_STD:  s = '{last_slot: 5'd5,  sample_slot: 5'd2, drive_slot: 5'd4, reconfirm: 3'd2};
            SPD_FAST: s = '{last_slot: 5'd4,  sample_slot: 5'd2, drive_slot: 5'd3, reconfirm: 3'd1};
            default:  s = '{last_slot: 5'd16, sample_slot: 5'd6, drive_slot: 5'd7, reconfirm: 3'd6};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/scl_sync.sv
// Module: scl_sync
// Multi-flop synchronizer for the sensed SCL level. It assumes the line idles
// high, so every stage resets to 1. STAGES must be at least 2.
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous line level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scl_prescaler.sv
// Module: scl_prescaler
// Divides the clock by div_val+1. It produces a one-cycle tick whenever the
// counter reaches div_val, and holds the counter at zero while run is low.
// div_val is expected to change only in the cycle of a tick.
module scl_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div_val);

    // Count cycles up to the divider value, then wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/scl_phase_seq.sv
// Module: scl_phase_seq
// Walks the per-mode slot schedule on prescaler ticks. It drives the pull-down,
// holds the period while a client stretches the clock, checks the low phase,
// and captures baud/mode at every period start. It assumes scl_s is already
// synchronized and each tick lasts longer than the synchronizer delay.
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              scl_s,
    input  logic [BAUD_W-1:0] baud_in,
    input  logic [1:0]        mode_in,
    output logic [BAUD_W-1:0] baud_q,
    output logic              run,
    output logic              pull_low,
    output logic              period_done,
    output logic              stretch_active,
    output logic              low_err
);
    sched_t            sch_q;
    logic [SLOT_W-1:0] slot;
    logic [CONF_W-1:0] conf;
    logic              stretch;
    logic              err_q;
    logic              done_q;

    // Capture configuration, advance slots, handle stretching and low checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot    <= '0;
            conf    <= '0;
            stretch <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            baud_q  <= '0;
            sch_q   <= sched_for(2'd0);
        end else if (!en) begin
            slot    <= '0;
            conf    <= '0;
            stretch <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (slot == '0) begin
                slot   <= SLOT_W'(1);
                baud_q <= baud_in;
                sch_q  <= sched_for(mode_in);
            end else if (tick) begin
                if (slot == sch_q.last_slot) begin
                    if (scl_s) err_q <= 1'b1;
                    slot   <= SLOT_W'(1);
                    done_q <= 1'b1;
                    baud_q <= baud_in;
                    sch_q  <= sched_for(mode_in);
                end else if (slot > sch_q.drive_slot) begin
                    if (scl_s) err_q <= 1'b1;
                    slot <= slot + 1'b1;
                end else if (slot == sch_q.drive_slot) begin
                    slot <= slot + 1'b1;
                end else if (slot >= sch_q.sample_slot) begin
                    if (stretch) begin
                        if (scl_s) begin
                            stretch <= 1'b0;
                            conf    <= sch_q.reconfirm;
                        end
                    end else if (conf != '0) begin
                        if (!scl_s) begin
                            stretch <= 1'b1;
                            conf    <= '0;
                        end else if (conf == CONF_W'(1)) begin
                            conf <= '0;
                            slot <= sch_q.drive_slot;
                        end else begin
                            conf <= conf - 1'b1;
                        end
                    end else if (scl_s) begin
                        slot <= slot + 1'b1;
                    end else begin
                        stretch <= 1'b1;
                    end
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    assign run            = (slot != '0);
    assign pull_low       = (slot != '0) && (slot >= sch_q.drive_slot);
    assign period_done    = done_q;
    assign stretch_active = stretch;
    assign low_err        = err_q;
endmodule

// File: rtl/scl_clkgen.sv
// Module: scl_clkgen (top)
// I2C host SCL generator: a synchronizer, a tick prescaler and a slot
// sequencer. The pad is assumed to be open-drain with an external pull-up;
// scl_pull_low enables the pull-down and nothing ever drives the line high.
module scl_clkgen #(
    parameter int BAUD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BAUD_W-1:0] baud,
    input  logic [1:0]        mode,
    input  logic              scl_in,
    output logic              scl_pull_low,
    output logic              period_done,
    output logic              stretch_active,
    output logic              low_err
);
    logic              scl_s;
    logic              tick;
    logic              run;
    logic [BAUD_W-1:0] baud_q;

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (scl_in),
        .q     (scl_s)
    );

    scl_prescaler #(.DIV_W(BAUD_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_val (baud_q),
        .tick    (tick)
    );

    scl_phase_seq #(.BAUD_W(BAUD_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .tick           (tick),
        .scl_s          (scl_s),
        .baud_in        (baud),
        .mode_in        (mode),
        .baud_q         (baud_q),
        .run            (run),
        .pull_low       (scl_pull_low),
        .period_done    (period_done),
        .stretch_active (stretch_active),
        .low_err        (low_err)
    );
endmodule

// File: rtl/scl_clkgen_chk.sv
// Module: scl_clkgen_chk
// Port-level properties of the SCL generator, bound onto every instance of
// scl_clkgen. It assumes the reset is synchronous and active low.
module scl_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_pull_low,
    input logic period_done,
    input logic stretch_active,
    input logic low_err
);
    // R9
    start_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |-> !scl_pull_low);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |=> !period_done);

    // R8
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_pull_low && !period_done && !stretch_active && !low_err));

    // R5
    stretch_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_active |-> !scl_pull_low);

    // R6
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_err && en) |=> low_err);

    // R4
    release_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_pull_low) |-> (period_done || !$past(en)));
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .scl_pull_low   (scl_pull_low),
    .period_done    (period_done),
    .stretch_active (stretch_active),
    .low_err        (low_err)
);

// File: tb/scl_clkgen_tb.sv
// Bench for scl_clkgen: sweeps every mode over several baud values and
// computes period lengths and low times arithmetically. It then covers
// stretching, the check-low error, config capture and disable.
module scl_clkgen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] baud = 8'd3;
    logic [1:0] mode = 2'd1;
    logic       client_hold = 1'b0;
    logic       force_hi = 1'b0;
    logic       scl_line;
    logic       scl_pull_low, period_done, stretch_active, low_err;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Wired-AND line with pull-up; force_hi models a stuck-high fault.
    assign scl_line = force_hi | !(scl_pull_low | client_hold);

    scl_clkgen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .baud           (baud),
        .mode           (mode),
        .scl_in         (scl_line),
        .scl_pull_low   (scl_pull_low),
        .period_done    (period_done),
        .stretch_active (stretch_active),
        .low_err        (low_err)
    );

    function automatic int ticks_of(input int m);
        return (m == 0) ? 5 : (m == 1) ? 4 : 16;
    endfunction
    function automatic int drive_of(input int m);
        return (m == 0) ? 4 : (m == 1) ? 3 : 7;
    endfunction
    function automatic int sample_of(input int m);
        return (m == 2 || m == 3) ? 6 : 2;
    endfunction
    function automatic int extra_of(input int m);
        return (m == 0) ? 2 : (m == 1) ? 1 : 6;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!period_done);
    endtask

    // Starting at a strobe, measure one period and its pulled-low cycles.
    task automatic measure(output int len, output int lowc);
        len = 0;
        lowc = 0;
        do begin
            @(negedge clk);
            len++;
            if (scl_pull_low) lowc++;
        end while (!period_done);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int len, lowc, cnt, b, m, exp;
        bit bad;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(!scl_pull_low && !period_done && !stretch_active && !low_err,
              "R10 reset outputs", int'({scl_pull_low, period_done, stretch_active, low_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_pull_low && !period_done, "R10 idle after reset", int'(scl_pull_low), 0);

        // R1 R2 R3 R4 R9: sweep every mode code over several baud values
        en = 1'b1;
        for (int mi = 0; mi < 4; mi++) begin
            for (int bi = 0; bi < 4; bi++) begin
                b = (bi == 0) ? 2 : (bi == 1) ? 3 : (bi == 2) ? 4 : 7;
                m = mi;
                baud = 8'(b);
                mode = 2'(m);
                wait_done();
                check(!scl_pull_low, "R9 released at strobe", int'(scl_pull_low), 0);
                measure(len, lowc);
                exp = ticks_of(m) * (b + 1);
                if (m == 0)      check(len == exp, "R1 period mode0", len, exp);
                else if (m == 1) check(len == exp, "R2 period mode1", len, exp);
                else             check(len == exp, "R3 period mode2/3", len, exp);
                exp = (ticks_of(m) - drive_of(m) + 1) * (b + 1);
                check(lowc == exp, "R4 low time", lowc, exp);
                @(negedge clk);
                check(!period_done, "R9 strobe one cycle", int'(period_done), 0);
            end
        end
        check(!low_err, "R6 no error on healthy line", int'(low_err), 0);

        // R5: client stretch in modes 0, 1 and 2 with baud 3
        for (int mi = 0; mi < 3; mi++) begin
            m = mi;
            b = 3;
            baud = 8'(b);
            mode = 2'(m);
            wait_done();
            wait_done();
            do @(negedge clk); while (!scl_pull_low);
            client_hold = 1'b1;
            wait_done();
            cnt = (sample_of(m) + 1) * (b + 1);
            repeat (cnt) @(posedge clk);
            @(negedge clk);
            check(stretch_active && !scl_pull_low, "R5 stretch status", int'(stretch_active), 1);
            client_hold = 1'b0;
            do begin
                @(negedge clk);
                cnt++;
            end while (!period_done);
            exp = (sample_of(m) + 1 + extra_of(m) + ticks_of(m) - drive_of(m) + 2) * (b + 1);
            check(cnt == exp, "R5 stretched period", cnt, exp);
            check(!low_err, "R5 no error after stretch", int'(low_err), 0);
        end

        // R7: config changed mid-period takes effect next period
        baud = 8'd3;
        mode = 2'd1;
        wait_done();
        wait_done();
        cnt = 0;
        repeat (5) begin
            @(negedge clk);
            cnt++;
        end
        baud = 8'd7;
        mode = 2'd0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!period_done);
        check(cnt == 16, "R7 current period unchanged", cnt, 16);
        measure(len, lowc);
        check(len == 40, "R7 new config next period", len, 40);

        // R6: line stuck high during check slots
        baud = 8'd3;
        mode = 2'd1;
        wait_done();
        force_hi = 1'b1;
        wait_done();
        check(low_err, "R6 error set", int'(low_err), 1);
        force_hi = 1'b0;
        wait_done();
        wait_done();
        check(low_err, "R6 error sticky", int'(low_err), 1);

        // R8: disable mid low phase
        do @(negedge clk); while (!scl_pull_low);
        en = 1'b0;
        @(negedge clk);
        check(!scl_pull_low && !low_err, "R8 disable releases and clears",
              int'({scl_pull_low, low_err}), 0);
        bad = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (scl_pull_low || period_done || stretch_active) bad = 1'b1;
        end
        check(!bad, "R8 idle while disabled", int'(bad), 0);
        en = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!period_done);
        check(cnt == 17, "R8 first period after enable", cnt, 17);

        // R10: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check(!scl_pull_low && !period_done && !low_err, "R10 reset mid-run",
              int'(scl_pull_low), 0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end
endmodule